// File: doc/BRIEF.md
# Segmented Core Address Decoder

This block sits between a host bus and a collection of cores inside an accelerator fabric. It takes the host's byte address, drops the byte offset to get a word address, and decodes that word address in two steps. The first step picks a core-type segment: hash, random-number, cipher, or a reserved fourth code. The second step picks a core slot inside that segment. The selected core receives a chip-select. Write-enable, the local register index and write data are broadcast to every core. Cores answer combinationally, so the decoder captures the selected core's answer in an output register on the clock edge. Read data therefore appears one cycle after the request.

Which slots exist is fixed at build time by one enable mask per segment. A disabled slot, a slot index past the configured count, a register index a core does not implement, and the reserved segment all behave as empty space: writes vanish and reads return zero. No error indication is raised. Slot 0 of the hash segment holds board-level registers: a fixed board identifier, a fixed build version and one writable scratch word. All other enabled slots hold small register-bank stubs that stand in for the real engines: each has one fixed identity word and a few writable words.

Top module: `core_addr_decoder`

## Requirements
- R1: The word address is host_addr[18:2], and host_addr[1:0] has no effect. The segment field is host_addr[18:17], the slot field is host_addr[16:10] and the register index is host_addr[9:2]. Segment codes are 0 for hash, 1 for random-number, 2 for cipher and 3 for reserved.
- R2: At hash slot 0, register 0x00 reads BOARD_ID and register 0x01 reads BUILD_VER. Writes to these two registers leave them unchanged.
- R3: At hash slot 0, register 0xFF is a writable scratch word that reads back the last value written. Reset clears it to zero.
- R4: Every other enabled slot reads register 0x00 as 0x5A000000 | (segment << 8) | slot. Registers 0x01 to 0x04 of such a slot are writable words that reset to zero.
- R5: A read sampled on a clock edge (host_cs=1, host_we=0) shows its data on host_rdata right after that edge, and not before.
- R6: host_rdata is zero after reset. It holds its value through idle cycles and write cycles.
- R7: Reads return zero from the reserved segment, a disabled slot, a slot index at or above NUM_SLOTS, and an unimplemented register index. Writes to any of these change no register.
- R8: Within one cycle at most one core is selected, and none is selected when host_cs is low. A write reaches only the addressed slot, even when other slots share the same register index.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_cs | input | 1 | Access request this cycle |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 19 | Host byte address |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Registered read data |

## Verification
The bench goes after the empty regions: the reserved segment, a masked slot, slot indices past the configured count, and register gaps inside a core. A decoder that aliased one of these onto a real core would return non-zero data, or would let a stray write corrupt a neighbouring slot that shares the same register index. Back-to-back reads pin the latency at exactly one cycle. An output that was not registered, or that was registered twice, would show the wrong word at the sampling point. Idle cycles and writes between reads catch an output register that is reloaded when it should hold, and reads with non-zero byte offsets catch any use of the offset bits.

// File: rtl/coredec_pkg.sv
// coredec_pkg: shared widths, the segment code type and the word-address
// layout used by the segmented core address decoder.
// Assumes SEG_W + SLOT_W + REG_W equals the word-address width.
package coredec_pkg;

    localparam int HOST_AW  = 19;
    localparam int BYTE_OFS = 2;
    localparam int WORD_AW  = HOST_AW - BYTE_OFS;
    localparam int SEG_W    = 2;
    localparam int SLOT_W   = 7;
    localparam int REG_W    = WORD_AW - SEG_W - SLOT_W;
    localparam int DATA_W   = 32;

    localparam logic [DATA_W-1:0] STUB_BASE = 32'h5A00_0000;

    typedef enum logic [SEG_W-1:0] {
        SEG_HASH   = 2'd0,
        SEG_RNG    = 2'd1,
        SEG_CIPHER = 2'd2,
        SEG_RSVD   = 2'd3
    } seg_e;

    typedef struct packed {
        logic [SEG_W-1:0]  seg;
        logic [SLOT_W-1:0] slot;
        logic [REG_W-1:0]  regi;
    } word_addr_t;

endpackage

// File: rtl/stub_core.sv
// stub_core: register-bank stand-in for a real engine.
// Register 0 returns a fixed identity word. Registers 1..NUM_RW are
// writable words. Every other index reads zero and ignores writes.
// Read data is combinational. The caller registers it.
module stub_core #(
    parameter int                DATA_W  = 32,
    parameter int                REG_W   = 8,
    parameter int                NUM_RW  = 4,
    parameter logic [DATA_W-1:0] ID_WORD = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              we,
    input  logic [REG_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] rw_q [NUM_RW];

    for (genvar i = 0; i < NUM_RW; i++) begin : g_rw
        // purpose: load one writable word when it is addressed by a selected write
        always_ff @(posedge clk) begin
            if (!rst_n)
                rw_q[i] <= '0;
            else if (cs && we && reg_addr == REG_W'(i + 1))
                rw_q[i] <= wdata;
        end

        // R4/R7: with no selected write, the word must not move
        p_stub_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
            !(cs && we) |=> $stable(rw_q[i]));
    end

    // purpose: combinational register read, zero for unimplemented indices
    always_comb begin
        rdata = '0;
        if (reg_addr == '0)
            rdata = ID_WORD;
        for (int i = 0; i < NUM_RW; i++)
            if (reg_addr == REG_W'(i + 1))
                rdata = rw_q[i];
    end

endmodule

// File: rtl/board_regs.sv
// board_regs: board-level register bank that occupies hash slot 0.
// Index 0x00 is the fixed board identifier, 0x01 the fixed build version,
// and 0xFF a writable scratch word. Other indices read zero and ignore writes.
// Read data is combinational. Assumes REG_W >= 8.
module board_regs #(
    parameter int                DATA_W    = 32,
    parameter int                REG_W     = 8,
    parameter logic [DATA_W-1:0] BOARD_ID  = '0,
    parameter logic [DATA_W-1:0] BUILD_VER = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              we,
    input  logic [REG_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam logic [REG_W-1:0] IDX_ID      = REG_W'(8'h00);
    localparam logic [REG_W-1:0] IDX_VER     = REG_W'(8'h01);
    localparam logic [REG_W-1:0] IDX_SCRATCH = REG_W'(8'hFF);

    logic [DATA_W-1:0] scratch_q;

    // purpose: scratch word, cleared by reset and loaded by a selected write
    always_ff @(posedge clk) begin
        if (!rst_n)
            scratch_q <= '0;
        else if (cs && we && reg_addr == IDX_SCRATCH)
            scratch_q <= wdata;
    end

    // purpose: combinational register read
    always_comb begin
        case (reg_addr)
            IDX_ID:      rdata = BOARD_ID;
            IDX_VER:     rdata = BUILD_VER;
            IDX_SCRATCH: rdata = scratch_q;
            default:     rdata = '0;
        endcase
    end

    // R3: a selected scratch write is visible on the next cycle
    p_scratch_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && we && reg_addr == IDX_SCRATCH) |=> scratch_q == $past(wdata));

    // R3: without such a write the scratch word holds
    p_scratch_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(cs && we) |=> $stable(scratch_q));

endmodule

// File: rtl/segment_sel.sv
// segment_sel: second decode level. Turns the slot field into one core
// select within a segment, builds the enabled cores, and muxes their
// combinational read data. Slots whose SLOT_EN bit is clear are not built
// and act as empty space. When HAS_BOARD is set, slot 0 is the board bank.
// Assumes NUM_SLOTS <= 2**SLOT_W.
module segment_sel
    import coredec_pkg::*;
#(
    parameter int                SEG_CODE  = 0,
    parameter int                NUM_SLOTS = 4,
    parameter logic [NUM_SLOTS-1:0] SLOT_EN = '1,
    parameter bit                HAS_BOARD = 1'b0,
    parameter int                NUM_RW    = 4,
    parameter logic [DATA_W-1:0] BOARD_ID  = '0,
    parameter logic [DATA_W-1:0] BUILD_VER = '0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 seg_sel,
    input  logic                 we,
    input  logic [SLOT_W-1:0]    slot,
    input  logic [REG_W-1:0]     reg_addr,
    input  logic [DATA_W-1:0]    wdata,
    output logic [DATA_W-1:0]    rdata,
    output logic [NUM_SLOTS-1:0] slot_cs
);

    logic [NUM_SLOTS-1:0] slot_hit;
    logic [DATA_W-1:0]    core_rd [NUM_SLOTS];

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        assign slot_hit[i] = SLOT_EN[i] && (slot == SLOT_W'(i));
        assign slot_cs[i]  = seg_sel && slot_hit[i];

        if (!SLOT_EN[i]) begin : g_empty
            assign core_rd[i] = '0;
        end else if (HAS_BOARD && i == 0) begin : g_board
            board_regs #(
                .DATA_W   (DATA_W),
                .REG_W    (REG_W),
                .BOARD_ID (BOARD_ID),
                .BUILD_VER(BUILD_VER)
            ) u_board (
                .clk     (clk),
                .rst_n   (rst_n),
                .cs      (slot_cs[i]),
                .we      (we),
                .reg_addr(reg_addr),
                .wdata   (wdata),
                .rdata   (core_rd[i])
            );
        end else begin : g_stub
            stub_core #(
                .DATA_W (DATA_W),
                .REG_W  (REG_W),
                .NUM_RW (NUM_RW),
                .ID_WORD(STUB_BASE | (DATA_W'(SEG_CODE) << 8) | DATA_W'(i))
            ) u_stub (
                .clk     (clk),
                .rst_n   (rst_n),
                .cs      (slot_cs[i]),
                .we      (we),
                .reg_addr(reg_addr),
                .wdata   (wdata),
                .rdata   (core_rd[i])
            );
        end
    end

    // purpose: AND-OR read mux over the slot hits, zero when nothing matches
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_SLOTS; i++)
            rdata = rdata | (slot_hit[i] ? core_rd[i] : '0);
    end

    // R8: the slot field can match at most one slot
    p_slot_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(slot_hit));

endmodule

// File: rtl/core_addr_decoder.sv
// core_addr_decoder: top of the two-level decoder. Splits the host word
// address into segment, slot and register fields, selects a segment, and
// registers the chosen core's read data (one cycle of latency). Empty
// regions drop writes and read as zero, with no error signal.
// Assumes a single-cycle access per host_cs pulse.
module core_addr_decoder
    import coredec_pkg::*;
#(
    parameter int                   NUM_SLOTS = 4,
    parameter logic [NUM_SLOTS-1:0] HASH_EN   = 4'b0111,
    parameter logic [NUM_SLOTS-1:0] RNG_EN    = 4'b0011,
    parameter logic [NUM_SLOTS-1:0] CIPHER_EN = 4'b0101,
    parameter int                   NUM_RW    = 4,
    parameter logic [DATA_W-1:0]    BOARD_ID  = 32'h4244_0001,
    parameter logic [DATA_W-1:0]    BUILD_VER = 32'h0002_0003
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_cs,
    input  logic               host_we,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [DATA_W-1:0]  host_wdata,
    output logic [DATA_W-1:0]  host_rdata
);

    localparam int TOTAL_SLOTS = 3 * NUM_SLOTS;

    word_addr_t        wa;
    logic              unused_byte_ofs;
    logic [2:0]        seg_sel;
    logic [DATA_W-1:0] rd_hash, rd_rng, rd_cipher, rd_mux;
    logic [NUM_SLOTS-1:0] cs_hash, cs_rng, cs_cipher;
    logic [TOTAL_SLOTS-1:0] all_cs;
    logic [DATA_W-1:0] rdata_q;

    assign wa              = host_addr[HOST_AW-1:BYTE_OFS];
    assign unused_byte_ofs = ^host_addr[BYTE_OFS-1:0];

    // purpose: first decode level, one select per implemented segment
    always_comb begin
        seg_sel[0] = host_cs && (seg_e'(wa.seg) == SEG_HASH);
        seg_sel[1] = host_cs && (seg_e'(wa.seg) == SEG_RNG);
        seg_sel[2] = host_cs && (seg_e'(wa.seg) == SEG_CIPHER);
    end

    segment_sel #(
        .SEG_CODE(0), .NUM_SLOTS(NUM_SLOTS), .SLOT_EN(HASH_EN),
        .HAS_BOARD(1'b1), .NUM_RW(NUM_RW),
        .BOARD_ID(BOARD_ID), .BUILD_VER(BUILD_VER)
    ) u_seg_hash (
        .clk(clk), .rst_n(rst_n), .seg_sel(seg_sel[0]), .we(host_we),
        .slot(wa.slot), .reg_addr(wa.regi), .wdata(host_wdata),
        .rdata(rd_hash), .slot_cs(cs_hash)
    );

    segment_sel #(
        .SEG_CODE(1), .NUM_SLOTS(NUM_SLOTS), .SLOT_EN(RNG_EN),
        .HAS_BOARD(1'b0), .NUM_RW(NUM_RW),
        .BOARD_ID(BOARD_ID), .BUILD_VER(BUILD_VER)
    ) u_seg_rng (
        .clk(clk), .rst_n(rst_n), .seg_sel(seg_sel[1]), .we(host_we),
        .slot(wa.slot), .reg_addr(wa.regi), .wdata(host_wdata),
        .rdata(rd_rng), .slot_cs(cs_rng)
    );

    segment_sel #(
        .SEG_CODE(2), .NUM_SLOTS(NUM_SLOTS), .SLOT_EN(CIPHER_EN),
        .HAS_BOARD(1'b0), .NUM_RW(NUM_RW),
        .BOARD_ID(BOARD_ID), .BUILD_VER(BUILD_VER)
    ) u_seg_cipher (
        .clk(clk), .rst_n(rst_n), .seg_sel(seg_sel[2]), .we(host_we),
        .slot(wa.slot), .reg_addr(wa.regi), .wdata(host_wdata),
        .rdata(rd_cipher), .slot_cs(cs_cipher)
    );

    assign all_cs = {cs_cipher, cs_rng, cs_hash};

    // purpose: segment-level read mux, reserved code reads zero
    always_comb begin
        case (seg_e'(wa.seg))
            SEG_HASH:   rd_mux = rd_hash;
            SEG_RNG:    rd_mux = rd_rng;
            SEG_CIPHER: rd_mux = rd_cipher;
            default:    rd_mux = '0;
        endcase
    end

    // purpose: output register, loaded only by a read, held otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata_q <= '0;
        else if (host_cs && !host_we)
            rdata_q <= rd_mux;
    end

    assign host_rdata = rdata_q;

    // R8: at most one core select in the whole fabric
    p_one_core_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(all_cs));

    // R8: no select without a host request
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !host_cs |-> all_cs == '0);

    // R6: output holds through idle and write cycles
    p_rdata_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_cs && !host_we) |=> $stable(host_rdata));

    // R7: a read of the reserved segment returns zero one cycle later
    p_rsvd_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (host_cs && !host_we && seg_e'(wa.seg) == SEG_RSVD) |=> host_rdata == '0);

endmodule

// File: tb/core_addr_decoder_bench.sv
// core_addr_decoder_bench: directed corner cases plus seeded random
// traffic, checked against a bench-side register model.
module core_addr_decoder_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NSLOT      = 4;
    localparam logic [3:0]  EN_HASH   = 4'b0111;
    localparam logic [3:0]  EN_RNG    = 4'b0011;
    localparam logic [3:0]  EN_CIPHER = 4'b0101;
    localparam logic [31:0] B_ID  = 32'h4244_0001;
    localparam logic [31:0] B_VER = 32'h0002_0003;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_cs = 1'b0;
    logic        host_we = 1'b0;
    logic [18:0] host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [31:0] m_scratch;
    logic [31:0] m_rw [3][NSLOT][4];

    always #(CLK_PERIOD/2) clk = ~clk;

    core_addr_decoder #(
        .NUM_SLOTS(NSLOT), .HASH_EN(EN_HASH), .RNG_EN(EN_RNG),
        .CIPHER_EN(EN_CIPHER), .NUM_RW(4), .BOARD_ID(B_ID), .BUILD_VER(B_VER)
    ) u_core_addr_decoder (
        .clk(clk), .rst_n(rst_n), .host_cs(host_cs), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata)
    );

    function automatic bit slot_on(int seg, int slot);
        if (seg > 2 || slot >= NSLOT) return 1'b0;
        case (seg)
            0: return EN_HASH[slot];
            1: return EN_RNG[slot];
            default: return EN_CIPHER[slot];
        endcase
    endfunction

    function automatic logic [31:0] expect_rd(int seg, int slot, int ri);
        if (!slot_on(seg, slot)) return '0;
        if (seg == 0 && slot == 0) begin
            if (ri == 0)    return B_ID;
            if (ri == 1)    return B_VER;
            if (ri == 255)  return m_scratch;
            return '0;
        end
        if (ri == 0) return 32'h5A00_0000 | (32'(seg) << 8) | 32'(slot);
        if (ri >= 1 && ri <= 4) return m_rw[seg][slot][ri-1];
        return '0;
    endfunction

    function automatic logic [18:0] mk_addr(int seg, int slot, int ri, int ofs);
        return {2'(seg), 7'(slot), 8'(ri), 2'(ofs)};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(int seg, int slot, int ri, logic [31:0] d, int ofs);
        @(negedge clk);
        host_cs = 1'b1; host_we = 1'b1;
        host_addr = mk_addr(seg, slot, ri, ofs); host_wdata = d;
        @(negedge clk);
        host_cs = 1'b0; host_we = 1'b0;
        if (slot_on(seg, slot)) begin
            if (seg == 0 && slot == 0) begin
                if (ri == 255) m_scratch = d;
            end else if (ri >= 1 && ri <= 4) begin
                m_rw[seg][slot][ri-1] = d;
            end
        end
    endtask

    task automatic rd(string req, int seg, int slot, int ri, int ofs);
        @(negedge clk);
        host_cs = 1'b1; host_we = 1'b0;
        host_addr = mk_addr(seg, slot, ri, ofs);
        @(negedge clk);
        host_cs = 1'b0;
        check(req, host_rdata, expect_rd(seg, slot, ri));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] held;
        void'($urandom(32'h00C0_FFEE));
        m_scratch = '0;
        for (int s = 0; s < 3; s++)
            for (int k = 0; k < NSLOT; k++)
                for (int r = 0; r < 4; r++)
                    m_rw[s][k][r] = '0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R6 reset value", host_rdata, '0);

        // R2 fixed board words, writes ignored
        rd("R2 board id", 0, 0, 0, 0);
        rd("R2 build version", 0, 0, 1, 0);
        wr(0, 0, 0, 32'hDEAD_BEEF, 0);
        wr(0, 0, 1, 32'h1234_5678, 0);
        rd("R2 id after write", 0, 0, 0, 0);
        rd("R2 version after write", 0, 0, 1, 0);

        // R3 scratch reset value and readback
        rd("R3 scratch reset", 0, 0, 255, 0);
        wr(0, 0, 255, 32'hA5A5_0F0F, 0);
        rd("R3 scratch readback", 0, 0, 255, 0);

        // R4 stub identity and writable words
        rd("R4 rng slot1 id", 1, 1, 0, 0);
        rd("R4 cipher slot2 id", 2, 2, 0, 0);
        rd("R4 rw reset", 1, 1, 2, 0);
        wr(1, 1, 2, 32'h0BAD_F00D, 0);
        rd("R4 rw readback", 1, 1, 2, 0);
        wr(0, 1, 4, 32'hFFFF_0001, 0);
        rd("R4 hash stub last rw", 0, 1, 4, 0);

        // R1 byte offset bits have no effect
        rd("R1 offset 3", 1, 1, 2, 3);
        wr(2, 0, 1, 32'h7777_1111, 2);
        rd("R1 write with offset", 2, 0, 1, 1);

        // R8 same register index in other slots untouched
        wr(1, 0, 3, 32'h1357_9BDF, 0);
        rd("R8 neighbour slot", 1, 1, 3, 0);
        rd("R8 other segment", 2, 0, 3, 0);
        rd("R8 target slot", 1, 0, 3, 0);

        // R7 empty regions
        wr(0, 3, 1, 32'hCAFE_CAFE, 0);
        rd("R7 disabled slot", 0, 3, 1, 0);
        rd("R7 disabled slot id", 1, 2, 0, 0);
        rd("R7 slot past count", 1, 5, 0, 0);
        wr(3, 0, 1, 32'h5555_AAAA, 0);
        rd("R7 reserved segment", 3, 0, 1, 0);
        rd("R7 reserved slot0 reg0", 3, 0, 0, 0);
        wr(1, 0, 9, 32'h9999_9999, 0);
        rd("R7 unimplemented index", 1, 0, 9, 0);
        rd("R7 no alias from dropped writes", 0, 1, 1, 0);

        // R5 exact one-cycle latency with back-to-back reads
        rd("R5 prime", 3, 0, 0, 0);
        @(negedge clk);
        host_cs = 1'b1; host_we = 1'b0; host_addr = mk_addr(0, 0, 0, 0);
        #1 check("R5 not before edge", host_rdata, '0);
        @(negedge clk);
        check("R5 first read", host_rdata, B_ID);
        host_addr = mk_addr(0, 0, 1, 0);
        @(negedge clk);
        host_cs = 1'b0;
        check("R5 second read", host_rdata, B_VER);

        // R6 hold across idle and write cycles
        held = host_rdata;
        repeat (3) @(negedge clk);
        check("R6 hold idle", host_rdata, held);
        wr(0, 0, 255, 32'h0000_0042, 0);
        check("R6 hold during write", host_rdata, held);

        // seeded random traffic
        for (int n = 0; n < 400; n++) begin
            int seg, slot, ri, pick, ofs;
            seg  = int'($urandom % 4);
            slot = int'($urandom % 6);
            pick = int'($urandom % 8);
            ofs  = int'($urandom % 4);
            ri   = (pick < 6) ? pick : ((pick == 6) ? 255 : int'($urandom % 256));
            if ($urandom % 2)
                wr(seg, slot, ri, $urandom, ofs);
            else if (!slot_on(seg, slot))
                rd("R7 random empty", seg, slot, ri, ofs);
            else if (seg == 0 && slot == 0)
                rd("R2/R3 random board", seg, slot, ri, ofs);
            else
                rd("R4 random stub", seg, slot, ri, ofs);
        end

        finish_run();
    end

endmodule